// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Controller

This block follows the device-level power state of a synchronous DRAM from its registered clock-enable pin and the class of the command decoded in the same cycle. It remembers the clock-enable sample from the previous cycle and compares it with the current one. A high-to-low change moves the device out of normal operation. Bank activity, a running burst and the command that comes with the change together decide whether the device enters clock suspend, power-down or self-refresh.

The other blocks of the memory model use the internal clock-enable output to freeze their burst counters and output registers. The refresh logic uses the self-refresh flag to run its own row sequencing. The current state is also brought out as a two-bit code. Row sequencing, input-buffer shutdown and timing limits belong to other blocks.

Top module: `cke_pwr_ctrl`

## Requirements
- R1: After reset the state is normal operation (code 0). The internal clock-enable is high and the self-refresh flag is low. While clock-enable stays sampled high, the state remains normal operation.
- R2: In normal operation, a clock-enable sample that was high in the previous cycle and is low in the current one moves the state to clock suspend (code 1) at that edge when not all banks are idle, whatever the command.
- R3: The same falling clock-enable with all banks idle, no burst running and a NOP (command class 1) or deselect (command class 2) moves the state to power-down (code 2).
- R4: The falling clock-enable with an auto-refresh command (command class 3), all banks idle and no burst running moves the state to self-refresh (code 3). An auto-refresh with banks still active enters clock suspend instead.
- R5: Clock suspend is held while clock-enable stays sampled low and is left for normal operation at the first edge where clock-enable is sampled high, whatever the command.
- R6: Power-down and self-refresh return to normal operation at the first edge where clock-enable is sampled high together with a NOP or deselect.
- R7: In power-down and self-refresh, every other input combination, including clock-enable high with a command of class 0 or 3, leaves the state unchanged.
- R8: A power-down request (falling clock-enable, all banks idle, NOP or deselect) made while a burst is in progress enters clock suspend.
- R9: The internal clock-enable output is high only in normal operation, and the self-refresh flag is high only in self-refresh. Both follow the state in the same cycle, so a low clock-enable sample always gives a low internal clock-enable from the next cycle.
- R10: A falling clock-enable with all banks idle, no burst and a command of class 0 (any other command) enters clock suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Registered clock-enable sample for this cycle |
| cmd_i | input | 2 | Command class: 0 other, 1 NOP, 2 deselect, 3 auto-refresh |
| banks_idle_i | input | 1 | High when every bank is precharged |
| burst_busy_i | input | 1 | High while a read or write burst is running |
| state_o | output | 2 | Power state: 0 run, 1 suspend, 2 power-down, 3 self-refresh |
| int_cke_o | output | 1 | Internal clock-enable for the other blocks |
| self_ref_o | output | 1 | High while in self-refresh |

## Verification
A wrong next-state choice shows on state_o and int_cke_o one edge after the clock-enable sample that caused it. For example, power-down in place of suspend during a burst appears at once as code 2 in place of 1. A state that ignores its exit condition, or that reacts to an ignored command, becomes visible at the exit cycle: int_cke_o stays low, or rises one cycle early. Each vector therefore checks all three outputs right after the edge that consumed it.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

   localparam int ST_W  = 2;
   localparam int CMD_W = 2;

   typedef enum logic [ST_W-1:0] {
      PS_RUN  = 2'd0,
      PS_SUSP = 2'd1,
      PS_PDN  = 2'd2,
      PS_SREF = 2'd3
   } pwr_state_t;

   typedef enum logic [CMD_W-1:0] {
      CC_OTHER = 2'd0,
      CC_NOP   = 2'd1,
      CC_DESEL = 2'd2,
      CC_AREF  = 2'd3
   } cmd_class_t;

   function automatic logic is_quiet(input cmd_class_t c);
      return (c == CC_NOP) || (c == CC_DESEL);
   endfunction

endpackage

// File: rtl/cke_pwr_sampler.sv
module cke_pwr_sampler #(
   parameter bit RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cke_i,
   output logic cke_prev_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_prev_o <= RESET_LEVEL;
      else        cke_prev_o <= cke_i;
   end

endmodule

// File: rtl/cke_pwr_nextstate.sv
module cke_pwr_nextstate
   import cke_pwr_pkg::*;
(
   input  pwr_state_t st_i,
   input  logic       cke_prev_i,
   input  logic       cke_now_i,
   input  cmd_class_t cmd_i,
   input  logic       idle_i,
   input  logic       busy_i,
   output pwr_state_t st_o
);

   logic falling;
   logic can_sleep;

   assign falling   = cke_prev_i && !cke_now_i;
   assign can_sleep = idle_i && !busy_i;

   always_comb begin
      st_o = st_i;
      unique case (st_i)
         PS_RUN: begin
            if (falling) begin
               if (can_sleep && (cmd_i == CC_AREF))  st_o = PS_SREF;
               else if (can_sleep && is_quiet(cmd_i)) st_o = PS_PDN;
               else                                   st_o = PS_SUSP;
            end
         end
         PS_SUSP: begin
            if (cke_now_i) st_o = PS_RUN;
         end
         PS_PDN, PS_SREF: begin
            if (cke_now_i && is_quiet(cmd_i)) st_o = PS_RUN;
         end
         default: st_o = PS_RUN;
      endcase
   end

endmodule

// File: rtl/cke_pwr_outdec.sv
module cke_pwr_outdec
   import cke_pwr_pkg::*;
#(
   parameter int N_STATES = 4
) (
   input  pwr_state_t st_i,
   output logic       int_cke_o,
   output logic       self_ref_o
);

   logic [N_STATES-1:0] hot;

   for (genvar s = 0; s < N_STATES; s++) begin : g_hot
      assign hot[s] = (st_i == pwr_state_t'(s));
   end

   if (N_STATES != (1 << ST_W)) begin : g_chk
      $error("cke_pwr_outdec: N_STATES must match state width");
   end

   assign int_cke_o  = hot[PS_RUN];
   assign self_ref_o = hot[PS_SREF];

   always_comb begin
      assert ($onehot0(hot)) else $error("a_r9_state_onehot: decode not one-hot");
   end

endmodule

// File: rtl/cke_pwr_ctrl.sv
module cke_pwr_ctrl
   import cke_pwr_pkg::*;
#(
   parameter int CMD_BITS   = 2,
   parameter int STATE_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cke_i,
   input  logic [CMD_BITS-1:0]   cmd_i,
   input  logic                  banks_idle_i,
   input  logic                  burst_busy_i,
   output logic [STATE_BITS-1:0] state_o,
   output logic                  int_cke_o,
   output logic                  self_ref_o
);

   localparam int NSTATES = 1 << STATE_BITS;

   if (CMD_BITS != CMD_W) begin : g_cmd_chk
      $error("cke_pwr_ctrl: CMD_BITS must equal package command width");
   end
   if (STATE_BITS != ST_W) begin : g_st_chk
      $error("cke_pwr_ctrl: STATE_BITS must equal package state width");
   end

   logic       cke_prev;
   pwr_state_t st_q;
   pwr_state_t st_d;

   cke_pwr_sampler #(.RESET_LEVEL(1'b1)) u_smp (
      .clk        (clk),
      .rst_n      (rst_n),
      .cke_i      (cke_i),
      .cke_prev_o (cke_prev)
   );

   cke_pwr_nextstate u_nxt (
      .st_i       (st_q),
      .cke_prev_i (cke_prev),
      .cke_now_i  (cke_i),
      .cmd_i      (cmd_class_t'(cmd_i)),
      .idle_i     (banks_idle_i),
      .busy_i     (burst_busy_i),
      .st_o       (st_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PS_RUN;
      else        st_q <= st_d;
   end

   cke_pwr_outdec #(.N_STATES(NSTATES)) u_dec (
      .st_i       (st_q),
      .int_cke_o  (int_cke_o),
      .self_ref_o (self_ref_o)
   );

   assign state_o = st_q;

   // R2: falling clock-enable with active banks enters suspend
   a_r2_active_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && cke_prev && !cke_i && !banks_idle_i) |=> (state_o == 2'd1));

   // R3: idle, quiet command, no burst enters power-down
   a_r3_enter_pdn: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && cke_prev && !cke_i && banks_idle_i && !burst_busy_i &&
       (cmd_i == 2'd1 || cmd_i == 2'd2)) |=> (state_o == 2'd2));

   // R4: self-refresh only entered from idle banks with auto-refresh
   a_r4_sref_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(self_ref_o) |-> ($past(banks_idle_i) && $past(cmd_i) == 2'd3 && !$past(cke_i)));

   // R7: sleeping states ignore all but the exit condition
   a_r7_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == PS_PDN || st_q == PS_SREF) && !(cke_i && (cmd_i == 2'd1 || cmd_i == 2'd2)))
      |=> $stable(state_o));

   // R8: burst turns a power-down request into suspend
   a_r8_burst_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && cke_prev && !cke_i && burst_busy_i) |=> (state_o == 2'd1));

   // R9: a low clock-enable sample gates the internal clock next cycle
   a_r9_low_cke_gates: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_i |=> !int_cke_o);

endmodule

// File: tb/cke_pwr_ctrl_tb_top.sv
module cke_pwr_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic [1:0] cmd = 2'd1;
   logic       idle = 1'b1;
   logic       busy = 1'b0;
   logic [1:0] st;
   logic       icke;
   logic       sref;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   cke_pwr_ctrl dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cke_i        (cke),
      .cmd_i        (cmd),
      .banks_idle_i (idle),
      .burst_busy_i (busy),
      .state_o      (st),
      .int_cke_o    (icke),
      .self_ref_o   (sref)
   );

   // vector: {cke, cmd[1:0], idle, busy, expected state[1:0]}
   localparam int NV = 24;
   localparam logic [6:0] VEC [NV] = '{
      {1'b1, 2'd1, 1'b1, 1'b0, 2'd0},  // R1 stay run
      {1'b0, 2'd1, 1'b1, 1'b0, 2'd2},  // R3 power-down by NOP
      {1'b0, 2'd0, 1'b1, 1'b0, 2'd2},  // R7 ignored
      {1'b1, 2'd0, 1'b1, 1'b0, 2'd2},  // R7 high with other cmd ignored
      {1'b1, 2'd3, 1'b1, 1'b0, 2'd2},  // R7 high with auto-refresh ignored
      {1'b1, 2'd2, 1'b1, 1'b0, 2'd0},  // R6 exit by deselect
      {1'b0, 2'd3, 1'b1, 1'b0, 2'd3},  // R4 self-refresh
      {1'b0, 2'd3, 1'b1, 1'b0, 2'd3},  // R7 held
      {1'b1, 2'd0, 1'b1, 1'b0, 2'd3},  // R7 ignored
      {1'b1, 2'd1, 1'b1, 1'b0, 2'd0},  // R6 exit by NOP
      {1'b1, 2'd0, 1'b0, 1'b0, 2'd0},  // R1 run with active banks
      {1'b0, 2'd0, 1'b0, 1'b0, 2'd1},  // R2 suspend
      {1'b0, 2'd1, 1'b0, 1'b0, 2'd1},  // R5 held while low
      {1'b1, 2'd0, 1'b0, 1'b0, 2'd0},  // R5 exit with any cmd
      {1'b0, 2'd1, 1'b1, 1'b1, 2'd1},  // R8 burst -> suspend
      {1'b1, 2'd1, 1'b1, 1'b0, 2'd0},  // R5 exit
      {1'b0, 2'd3, 1'b0, 1'b0, 2'd1},  // R4 auto-refresh with active banks
      {1'b1, 2'd1, 1'b1, 1'b0, 2'd0},  // R5 exit
      {1'b0, 2'd0, 1'b1, 1'b0, 2'd1},  // R10 idle with other cmd
      {1'b1, 2'd3, 1'b1, 1'b0, 2'd0},  // R5 exit
      {1'b0, 2'd2, 1'b1, 1'b0, 2'd2},  // R3 power-down by deselect
      {1'b1, 2'd1, 1'b1, 1'b0, 2'd0},  // R6 exit
      {1'b0, 2'd2, 1'b1, 1'b1, 2'd1},  // R8 burst with deselect
      {1'b1, 2'd2, 1'b1, 1'b0, 2'd0}   // R5 exit
   };

   task automatic check_out(input string req, input logic [1:0] exp_st);
      logic exp_icke;
      logic exp_sref;
      exp_icke = (exp_st == 2'd0);
      exp_sref = (exp_st == 2'd3);
      n_chk++;
      if (st !== exp_st || icke !== exp_icke || sref !== exp_sref) begin
         n_bad++;
         $display("FAIL %s: actual st=%0d icke=%b sref=%b expected st=%0d icke=%b sref=%b",
                  req, st, icke, sref, exp_st, exp_icke, exp_sref);
      end
   endtask

   task automatic step(input logic [6:0] v);
      @(negedge clk);
      cke  = v[6];
      cmd  = v[5:4];
      idle = v[3];
      busy = v[2];
      @(posedge clk);
      #1;
   endtask

   initial begin
      #200000;
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_out("R1 reset", 2'd0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i]);
         check_out($sformatf("vector %0d (R1..R10 per table)", i), VEC[i][1:0]);
      end

      // R9: internal clock-enable drops right after a low sample
      step({1'b0, 2'd0, 1'b0, 1'b0, 2'd1});
      check_out("R9 gated after low sample", 2'd1);
      step({1'b1, 2'd0, 1'b0, 1'b0, 2'd0});
      check_out("R9 re-enabled", 2'd0);

      // R1: reset during self-refresh returns to run
      step({1'b0, 2'd3, 1'b1, 1'b0, 2'd3});
      check_out("R4 before reset", 2'd3);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_out("R1 async reset", 2'd0);
      cke = 1'b1;
      cmd = 2'd1;
      @(negedge clk);
      rst_n = 1'b1;
      step({1'b1, 2'd0, 1'b1, 1'b0, 2'd0});
      check_out("R1 run after reset", 2'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule